// File: doc/BRIEF.md
# Two-Stage PCI Interrupt Lane Router

The block gathers the level interrupt requests of every function of several on-chip PCI devices onto eight shared PIRQ lines. The requests pass through two stages, both programmable. In the first stage, each function's pin code chooses the INTx lane that the function drives: INTA, INTB, INTC or INTD. A pin code can also switch the function off. In the second stage, each device's route register sends each of that device's four INTx lanes to one of the eight PIRQ lines. A PIRQ line is active while any request that reaches it through both stages is active.

Firmware programs the two register kinds through a plain write port and reads them back through a plain read port. No data stream crosses this block, so every pin is a plain level or strobe and there is no valid/ready handshake. The block also drives a read-only view of every function's pin code. An enumeration agent can present that view as the function's interrupt-pin value.

Top module: `irq_pin_mapper`

## Requirements
- R1: After reset, every pin code is 0. Every route register maps INTA to PIRQA, INTB to PIRQB, INTC to PIRQC and INTD to PIRQD, which reads back as 0x688. `pirq_o` is all zero whatever the requests are.
- R2: Pin code 1, 2, 3 or 4 makes the function drive INTA, INTB, INTC or INTD of its device, in that order. The pin code of function f of a device occupies bits [3f+2:3f] of that device's pin register.
- R3: A pin code of 0, 5, 6 or 7 disconnects the function. Its request then reaches no PIRQ line.
- R4: The route register of a device holds one 3-bit entry per lane, with lane n (INTA = 0 … INTD = 3) at bits [3n+2:3n]. Entry value k (0…7) sends that lane to PIRQ line k. PIRQA is bit 0 of `pirq_o`.
- R5: Each PIRQ output is the OR of every function request that reaches it. This holds when several functions share a lane and when several lanes, from one device or from different devices, share a PIRQ line.
- R6: `pin_view_o` presents each function's current pin code at bits [3(8d+f)+2:3(8d+f)] for device d and function f. It changes only through a write to the pin register.
- R7: The route entry of a lane that no function selects has no effect on any output.
- R8: A register write is captured on the clock edge at which `wr_en_i` is high. It acts on `pirq_o` and `pin_view_o` right after that edge.
- R9: Address bit 0 selects the pin register (0) or the route register (1), and the bits above it select the device. `rd_data_o` returns the addressed register combinationally. Bits above the register's width are dropped on a write and read as 0.
- R10: The PIRQ outputs are combinational levels. A PIRQ output falls in the same cycle as the last request feeding it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | $clog2(NUM_DEV)+1 | Write address: device above bit 0, register select in bit 0 |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | $clog2(NUM_DEV)+1 | Read address, same layout as the write address |
| rd_data_o | output | DATA_W | Contents of the register at `rd_addr_i` |
| func_irq_i | input | NUM_DEV*NUM_FUNC | Level request of function f of device d at bit NUM_FUNC*d+f |
| pirq_o | output | NUM_PIRQ | Shared PIRQ levels, PIRQA in bit 0 |
| pin_view_o | output | NUM_DEV*NUM_FUNC*3 | Read-only pin code of every function |

## Verification
Requests reach `pirq_o` through combinational logic only, so a request change is due in the same cycle. A register write is due half a cycle after the edge that captures it, and `rd_data_o` follows `rd_addr_i` with no delay. The bench changes inputs one time unit after a falling edge. It queues the expected value alongside each stimulus, and the monitor compares every queued item at the next falling edge. Each write queues a PIRQ check that the monitor compares at the first falling edge after the capturing rising edge, which pins down the one-edge latency of R8.

// File: rtl/irqmap_pkg.sv
package irqmap_pkg;

  localparam int LANES  = 4;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    PIN_OFF = 3'd0,
    PIN_A   = 3'd1,
    PIN_B   = 3'd2,
    PIN_C   = 3'd3,
    PIN_D   = 3'd4
  } pin_code_e;

  // Turn a pin code into a one-hot lane vector; unused codes give none.
  function automatic logic [LANES-1:0] lane_of(input logic [CODE_W-1:0] code);
    logic [LANES-1:0] hot;
    hot = '0;
    case (code)
      PIN_A:   hot = 4'b0001;
      PIN_B:   hot = 4'b0010;
      PIN_C:   hot = 4'b0100;
      PIN_D:   hot = 4'b1000;
      default: hot = '0;
    endcase
    return hot;
  endfunction

endpackage

// File: rtl/irqmap_regs.sv
module irqmap_regs
  import irqmap_pkg::*;
#(
  parameter int NUM_DEV  = 4,
  parameter int NUM_FUNC = 8,
  parameter int NUM_PIRQ = 8,
  parameter int DATA_W   = 32
) (
  input  logic                               clk_i,
  input  logic                               rst_i,
  input  logic                               wr_en_i,
  input  logic [$clog2(NUM_DEV):0]           wr_addr_i,
  input  logic [DATA_W-1:0]                  wr_data_i,
  input  logic [$clog2(NUM_DEV):0]           rd_addr_i,
  output logic [DATA_W-1:0]                  rd_data_o,
  output logic [NUM_DEV*NUM_FUNC*CODE_W-1:0] pin_flat_o,
  output logic [NUM_DEV*LANES*$clog2(NUM_PIRQ)-1:0] route_flat_o
);

  localparam int DEV_W   = $clog2(NUM_DEV);
  localparam int SEL_W   = $clog2(NUM_PIRQ);
  localparam int PIN_RW  = NUM_FUNC * CODE_W;
  localparam int ROUTE_RW = LANES * SEL_W;

  function automatic logic [ROUTE_RW-1:0] straight_route();
    logic [ROUTE_RW-1:0] r;
    r = '0;
    for (int l = 0; l < LANES; l++) r[l*SEL_W +: SEL_W] = SEL_W'(l % NUM_PIRQ);
    return r;
  endfunction

  localparam logic [ROUTE_RW-1:0] ROUTE_RST = straight_route();

  logic [PIN_RW-1:0]   pin_r   [NUM_DEV];
  logic [ROUTE_RW-1:0] route_r [NUM_DEV];
  logic [DEV_W-1:0]    wr_dev, rd_dev;

  assign wr_dev = wr_addr_i[DEV_W:1];
  assign rd_dev = rd_addr_i[DEV_W:1];

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        pin_r[d]   <= '0;
        route_r[d] <= ROUTE_RST;
      end else if (wr_en_i && (wr_dev == DEV_W'(d))) begin
        if (wr_addr_i[0]) route_r[d] <= wr_data_i[ROUTE_RW-1:0];
        else              pin_r[d]   <= wr_data_i[PIN_RW-1:0];
      end
    end
    assign pin_flat_o[d*PIN_RW +: PIN_RW]       = pin_r[d];
    assign route_flat_o[d*ROUTE_RW +: ROUTE_RW] = route_r[d];
  end

  always_comb begin
    rd_data_o = '0;
    if (int'(rd_dev) < NUM_DEV) begin
      if (rd_addr_i[0]) rd_data_o[ROUTE_RW-1:0] = route_r[rd_dev];
      else              rd_data_o[PIN_RW-1:0]   = pin_r[rd_dev];
    end
  end

endmodule

// File: rtl/irqmap_dev_lanes.sv
module irqmap_dev_lanes
  import irqmap_pkg::*;
#(
  parameter int NUM_FUNC = 8
) (
  input  logic [NUM_FUNC*CODE_W-1:0] pin_codes_i,
  input  logic [NUM_FUNC-1:0]        func_req_i,
  output logic [LANES-1:0]           lane_req_o
);

  always_comb begin
    lane_req_o = '0;
    for (int f = 0; f < NUM_FUNC; f++) begin
      lane_req_o = lane_req_o
                 | (lane_of(pin_codes_i[f*CODE_W +: CODE_W]) & {LANES{func_req_i[f]}});
    end
  end

endmodule

// File: rtl/irqmap_lane_route.sv
module irqmap_lane_route
  import irqmap_pkg::*;
#(
  parameter int NUM_PIRQ = 8
) (
  input  logic [LANES-1:0]                  lane_req_i,
  input  logic [LANES*$clog2(NUM_PIRQ)-1:0] route_i,
  output logic [NUM_PIRQ-1:0]               pirq_o
);

  localparam int SEL_W = $clog2(NUM_PIRQ);

  always_comb begin
    pirq_o = '0;
    for (int l = 0; l < LANES; l++) begin
      if (lane_req_i[l] && (int'(route_i[l*SEL_W +: SEL_W]) < NUM_PIRQ)) begin
        pirq_o[route_i[l*SEL_W +: SEL_W]] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_pin_mapper.sv
module irq_pin_mapper
  import irqmap_pkg::*;
#(
  parameter int NUM_DEV  = 4,
  parameter int NUM_FUNC = 8,
  parameter int NUM_PIRQ = 8,
  parameter int DATA_W   = 32
) (
  input  logic                               clk_i,
  input  logic                               rst_i,
  input  logic                               wr_en_i,
  input  logic [$clog2(NUM_DEV):0]           wr_addr_i,
  input  logic [DATA_W-1:0]                  wr_data_i,
  input  logic [$clog2(NUM_DEV):0]           rd_addr_i,
  output logic [DATA_W-1:0]                  rd_data_o,
  input  logic [NUM_DEV*NUM_FUNC-1:0]        func_irq_i,
  output logic [NUM_PIRQ-1:0]                pirq_o,
  output logic [NUM_DEV*NUM_FUNC*3-1:0]      pin_view_o
);

  localparam int SEL_W    = $clog2(NUM_PIRQ);
  localparam int PIN_RW   = NUM_FUNC * CODE_W;
  localparam int ROUTE_RW = LANES * SEL_W;

  logic [NUM_DEV*PIN_RW-1:0]   pin_flat;
  logic [NUM_DEV*ROUTE_RW-1:0] route_flat;
  logic [NUM_PIRQ-1:0]         dev_pirq [NUM_DEV];

  irqmap_regs #(
    .NUM_DEV (NUM_DEV),
    .NUM_FUNC(NUM_FUNC),
    .NUM_PIRQ(NUM_PIRQ),
    .DATA_W  (DATA_W)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .rd_addr_i   (rd_addr_i),
    .rd_data_o   (rd_data_o),
    .pin_flat_o  (pin_flat),
    .route_flat_o(route_flat)
  );

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic [LANES-1:0] lane_req;

    irqmap_dev_lanes #(.NUM_FUNC(NUM_FUNC)) u_lanes (
      .pin_codes_i(pin_flat[d*PIN_RW +: PIN_RW]),
      .func_req_i (func_irq_i[d*NUM_FUNC +: NUM_FUNC]),
      .lane_req_o (lane_req)
    );

    irqmap_lane_route #(.NUM_PIRQ(NUM_PIRQ)) u_route (
      .lane_req_i(lane_req),
      .route_i   (route_flat[d*ROUTE_RW +: ROUTE_RW]),
      .pirq_o    (dev_pirq[d])
    );
  end

  always_comb begin
    pirq_o = '0;
    for (int d = 0; d < NUM_DEV; d++) pirq_o = pirq_o | dev_pirq[d];
  end

  assign pin_view_o = pin_flat;

endmodule

// File: rtl/irq_pin_mapper_chk.sv
module irq_pin_mapper_chk #(
  parameter int NUM_DEV  = 4,
  parameter int NUM_FUNC = 8,
  parameter int NUM_PIRQ = 8,
  parameter int DATA_W   = 32
) (
  input logic                          clk_i,
  input logic                          rst_i,
  input logic                          wr_en_i,
  input logic [$clog2(NUM_DEV):0]      wr_addr_i,
  input logic [DATA_W-1:0]             wr_data_i,
  input logic [NUM_DEV*NUM_FUNC-1:0]   func_irq_i,
  input logic [NUM_PIRQ-1:0]           pirq_o,
  input logic [NUM_DEV*NUM_FUNC*3-1:0] pin_view_o
);

  localparam int DEV_W  = $clog2(NUM_DEV);
  localparam int PIN_RW = NUM_FUNC * 3;

  logic [PIN_RW-1:0] pv [NUM_DEV];
  logic              any_live;
  logic              pin_wr_q;
  logic [DEV_W-1:0]  dev_q;
  logic [PIN_RW-1:0] data_q;

  always_comb begin
    any_live = 1'b0;
    for (int i = 0; i < NUM_DEV*NUM_FUNC; i++) begin
      if (pin_view_o[i*3 +: 3] >= 3'd1 && pin_view_o[i*3 +: 3] <= 3'd4) any_live = 1'b1;
    end
    for (int d = 0; d < NUM_DEV; d++) pv[d] = pin_view_o[d*PIN_RW +: PIN_RW];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pin_wr_q <= 1'b0;
      dev_q    <= '0;
      data_q   <= '0;
    end else begin
      pin_wr_q <= wr_en_i && !wr_addr_i[0] && (int'(wr_addr_i[DEV_W:1]) < NUM_DEV);
      dev_q    <= wr_addr_i[DEV_W:1];
      data_q   <= wr_data_i[PIN_RW-1:0];
    end
  end

  AST_IDLE_NO_PIRQ: assert property (@(posedge clk_i) disable iff (rst_i)
    (func_irq_i == '0) |-> (pirq_o == '0)); // R10

  AST_DISABLED_SILENT: assert property (@(posedge clk_i) disable iff (rst_i)
    !any_live |-> (pirq_o == '0)); // R3

  AST_PIN_VIEW_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
    !wr_en_i |=> $stable(pin_view_o)); // R6

  AST_PIN_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (rst_i)
    pin_wr_q |-> (pv[dev_q] == data_q)); // R8

  AST_PIRQ_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (rst_i)
    $countones(pirq_o) <= $countones(func_irq_i)); // R5

endmodule

bind irq_pin_mapper irq_pin_mapper_chk #(
  .NUM_DEV (NUM_DEV),
  .NUM_FUNC(NUM_FUNC),
  .NUM_PIRQ(NUM_PIRQ),
  .DATA_W  (DATA_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .func_irq_i(func_irq_i),
  .pirq_o    (pirq_o),
  .pin_view_o(pin_view_o)
);

// File: tb/irq_pin_mapper_tb.sv
module irq_pin_mapper_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic [2:0]  rd_addr;
  logic [31:0] rd_data;
  logic [31:0] req;
  logic [7:0]  pirq;
  logic [95:0] pin_view;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  irq_pin_mapper u_dut (
    .clk_i     (clk),
    .rst_i     (rst),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .func_irq_i(req),
    .pirq_o    (pirq),
    .pin_view_o(pin_view)
  );

  // Reference state, kept from the requirements
  logic [2:0] m_pin   [4][8];
  logic [2:0] m_route [4][4];

  function automatic logic [7:0] model_pirq(input logic [31:0] r);
    logic [7:0] p;
    p = '0;
    for (int d = 0; d < 4; d++)
      for (int f = 0; f < 8; f++)
        if (r[d*8+f] && m_pin[d][f] >= 3'd1 && m_pin[d][f] <= 3'd4)
          p[m_route[d][m_pin[d][f]-3'd1]] = 1'b1;
    return p;
  endfunction

  function automatic logic [95:0] model_view();
    logic [95:0] v;
    for (int d = 0; d < 4; d++)
      for (int f = 0; f < 8; f++) v[(d*8+f)*3 +: 3] = m_pin[d][f];
    return v;
  endfunction

  // Scoreboard: kind 0 = pirq, 1 = rd_data, 2 = pin_view
  int          q_kind [$];
  logic [95:0] q_exp  [$];
  string       q_tag  [$];

  always @(negedge clk) begin
    while (q_kind.size() > 0) begin
      int          k;
      logic [95:0] e;
      logic [95:0] a;
      string       t;
      k = q_kind.pop_front();
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      case (k)
        0:       a = {88'd0, pirq};
        1:       a = {64'd0, rd_data};
        default: a = pin_view;
      endcase
      n_checks++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", t, a, e);
      end
    end
  end

  task automatic push(input int k, input logic [95:0] e, input string t);
    q_kind.push_back(k);
    q_exp.push_back(e);
    q_tag.push_back(t);
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic check_pirq(input string t);
    push(0, {88'd0, model_pirq(req)}, t);
    settle();
  endtask

  task automatic check_rd(input logic [2:0] a, input logic [31:0] e, input string t);
    rd_addr = a;
    push(1, {64'd0, e}, t);
    settle();
  endtask

  task automatic check_view(input string t);
    push(2, model_view(), t);
    settle();
  endtask

  // A write lands on the next rising edge; its effect is checked at the falling edge after it.
  task automatic do_write(input int dev, input bit is_route, input logic [31:0] d);
    wr_addr = {2'(dev), is_route};
    wr_data = d;
    wr_en   = 1'b1;
    if (is_route) for (int l = 0; l < 4; l++) m_route[dev][l] = d[l*3 +: 3];
    else          for (int f = 0; f < 8; f++) m_pin[dev][f]   = d[f*3 +: 3];
    push(0, {88'd0, model_pirq(req)}, "R8 write effect one edge later");
    settle();
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0; req = '0;
    for (int d = 0; d < 4; d++) begin
      for (int f = 0; f < 8; f++) m_pin[d][f] = 3'd0;
      for (int l = 0; l < 4; l++) m_route[d][l] = 3'(l);
    end
    repeat (4) @(posedge clk);
    settle();
    rst = 1'b0;

    // R1: reset state
    req = '1;
    check_pirq("R1 quiet after reset");
    check_rd({2'd0, 1'b1}, 32'h688, "R1 route reset identity");
    check_rd({2'd2, 1'b0}, 32'h0, "R1 pin reset zero");
    check_view("R1 view reset");
    req = '0;

    // R2: pin codes 1..4 on device 0, identity route
    do_write(0, 1'b0, 32'h8D1);
    check_view("R6 view equals pin codes");
    for (int f = 0; f < 4; f++) begin
      req = 32'(1) << f;
      check_pirq("R2 pin code selects lane");
    end
    req = 32'h1;
    push(0, 96'h1, "R2 INTA to PIRQA");
    settle();

    // R8: reroute lane A of device 0 to PIRQF while its request is held
    do_write(0, 1'b1, 32'h68D);
    push(0, 96'h20, "R8 reroute visible after edge");
    settle();

    // R3: codes 5,6,7,0 disconnect
    req = '0;
    do_write(1, 1'b0, 32'h1F5);
    req = 32'hFF << 8;
    push(0, 96'h0, "R3 codes 0 and 5-7 silent");
    settle();

    // R4: reversed route on device 2
    req = '0;
    do_write(2, 1'b1, 32'h977);
    do_write(2, 1'b0, 32'h8D1);
    for (int f = 0; f < 4; f++) begin
      req = 32'(1) << (16 + f);
      push(0, {88'd0, 8'(8'h80 >> f)}, "R4 lane route to PIRQ");
      settle();
    end

    // R7: only INTA used on device 2; rewriting other entries changes nothing
    req = '0;
    do_write(2, 1'b0, 32'h001);
    req = 32'hFF << 16;
    check_pirq("R7 baseline");
    do_write(2, 1'b1, 32'h007);
    push(0, 96'h80, "R7 unused lane route no effect");
    settle();
    check_view("R6 view after writes");

    // R5: sharing of lane and of PIRQ line
    req = '0;
    do_write(3, 1'b1, 32'h03F);
    do_write(3, 1'b0, 32'h089);
    req = 32'h1 << 24;
    push(0, 96'h80, "R5 shared lane func0");
    settle();
    req = 32'h3 << 24;
    push(0, 96'h80, "R5 shared lane both");
    settle();
    req = (32'h7 << 24) | (32'h1 << 16) | 32'h1;
    check_pirq("R5 lanes from many devices");

    // R10: levels fall with the requests
    req = 32'h1 << 25;
    push(0, 96'h80, "R10 one source left");
    settle();
    req = '0;
    push(0, 96'h0, "R10 falls with last request");
    settle();

    // R9: readback with dropped upper bits
    do_write(3, 1'b1, 32'hFFFF_FFFF);
    check_rd({2'd3, 1'b1}, 32'h0000_0FFF, "R9 route readback masked");
    do_write(3, 1'b0, 32'hFFFF_FFFF);
    check_rd({2'd3, 1'b0}, 32'h00FF_FFFF, "R9 pin readback masked");
    req = 32'hFF << 24;
    push(0, 96'h0, "R3 code 7 silent");
    settle();
    check_rd({2'd0, 1'b0}, 32'h0000_08D1, "R9 device 0 pin readback");

    // R5: mixed patterns across a varied setup
    do_write(1, 1'b0, 32'h00A_C8D1);
    do_write(1, 1'b1, 32'h0B1E);
    do_write(3, 1'b0, 32'h0043_0A1C);
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 40; i++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      req = lfsr & (lfsr >> 7);
      check_pirq("R5 OR of reaching requests");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule